// File: doc/BRIEF.md
# Direction-Flag Pointer Stepper

This block works out where a 12-bit pointer moves next when one step is taken. The pointer may serve as an instruction, data or stack pointer. A 5-bit direction code selects the rule. Codes 0 to 26 are unit moves in a 3-D neighbourhood. These moves are applied to the segment's geometry, which is a linear array, a 64x64 grid or a 16x16x16 cube, and every coordinate wraps inside its own dimension. Codes 27 to 29 instead move by a signed stride, which may be taken modulo a wrap value or kept inside a block whose size is that wrap value. Codes 30 and 31 are not defined.

The same cycle also computes the opposite of the supplied direction code, so a caller can reverse its direction of travel. One strobe on `in_valid` starts a request. The next pointer, the reversed code and an error flag are registered and presented one clock later, qualified by `out_valid`.

Top module: `dir_ptr_stepper`

## Requirements
- R1: During and right after a synchronous active-low reset, `out_valid`, `ptr_out`, `rev_out` and `err_out` are all zero.
- R2: A request sampled with `in_valid` high produces its result on the outputs at the next rising edge, with `out_valid` high for exactly that cycle. While `in_valid` is low, `out_valid` is low and `ptr_out`, `rev_out` and `err_out` keep their last values.
- R3: A code c below 27 decodes to a unit move (dx, dy, dz). The layer c div 9 gives dz: layer 0 gives 0, layer 1 gives +1 and layer 2 gives -1. The position p = c mod 9 gives dx = +1 for p in {1,2,8} and dx = -1 for p in {4,5,6}, and gives dy = +1 for p in {2,3,4} and dy = -1 for p in {6,7,8}. Every other case gives 0. Code 0 leaves the pointer unchanged.
- R4: In a linear segment (`geom_in` 0, and also the unused value 3), next = (ptr + dx) mod 4096. dy and dz are ignored, so codes 1, 10 and 19 all move forward by one.
- R5: In a grid segment (`geom_in` 1), x is ptr[5:0] and y is ptr[11:6]. Each gets its offset added mod 64, and dz is ignored.
- R6: In a cube segment (`geom_in` 2), x is ptr[3:0], y is ptr[7:4] and z is ptr[11:8]. Each gets its offset added mod 16.
- R7: Code 27 gives next = (ptr + step) mod 4096 in any geometry, with `step_in` read as a signed two's-complement value. The modulus is ignored.
- R8: Code 28 gives next = ((ptr + step) mod 4096) mod M, where M is `mod_in` read as unsigned.
- R9: Code 29 gives next = (base + ((off + step) mod M)) mod 4096, where off = ptr mod M and base = ptr - off. The inner mod is mathematical, so its result always lies in 0..M-1, even for a negative step.
- R10: `err_out` is 1, and `ptr_out` equals the request's pointer, when the code is 30 or 31, or when the code is 28 or 29 and M is 0. In every other case `err_out` is 0.
- R11: `rev_out` gives the opposite direction. For codes below 27, layer 1 and layer 2 are swapped, position 0 stays 0, and any other position p becomes ((p+3) mod 8)+1. Examples are 1 to 5 and 13 to 26. Codes 27 to 31 are returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| ptr_in | input | 12 | Current pointer |
| dir_in | input | 5 | Direction code |
| step_in | input | 12 | Signed stride for codes 27 to 29 |
| mod_in | input | 12 | Unsigned wrap or block size for codes 28 and 29 |
| geom_in | input | 2 | Segment geometry: 0 linear, 1 grid, 2 cube, 3 linear |
| out_valid | output | 1 | Result valid, one cycle after the request |
| ptr_out | output | 12 | Next pointer |
| rev_out | output | 5 | Reversed direction code |
| err_out | output | 1 | Reserved code, or zero modulus on a modulus code |

## Verification
The assertions assume that every input is stable and known at each rising edge where `in_valid` is high. They also assume that `mod_in` is meaningful only for codes 28 and 29. The assertions compare each result with the request that was sampled one cycle earlier. For this reason the bench changes inputs only on falling edges, and it holds `in_valid` low during reset. The stimulus reaches every geometry, every wrap boundary in each dimension, negative strides, a modulus that does not divide 4096, and a modulus of zero. All of these stay inside the legal input space, so the error path is reached only through the reserved codes and a zero modulus.

// File: rtl/stepper_pkg.sv
// Shared constants and types for the direction-flag pointer stepper.
// Assumes a 5-bit direction code. The special code values are fixed.
package stepper_pkg;
    localparam int DIR_W = 5;

    localparam logic [DIR_W-1:0] DIR_NGEO   = 5'd27;  // first non-geometric code
    localparam logic [DIR_W-1:0] DIR_STRIDE = 5'd27;  // plain stride
    localparam logic [DIR_W-1:0] DIR_WRAP   = 5'd28;  // stride modulo M
    localparam logic [DIR_W-1:0] DIR_BLOCK  = 5'd29;  // stride inside M-sized block
    localparam logic [DIR_W-1:0] DIR_RSV    = 5'd30;  // first reserved code

    typedef enum logic [1:0] {
        GEO_LINE  = 2'd0,
        GEO_GRID  = 2'd1,
        GEO_CUBE  = 2'd2,
        GEO_SPARE = 2'd3
    } geom_e;
endpackage

// File: rtl/dir_decode.sv
// Decodes a direction code into a unit move (dx, dy, dz) in two's complement
// and computes the opposite code. Assumes codes 27 and above are not
// geometric: they give a zero move and come back unchanged as their reverse.
module dir_decode
    import stepper_pkg::*;
(
    input  logic [DIR_W-1:0] code,
    output logic [1:0]       dx,
    output logic [1:0]       dy,
    output logic [1:0]       dz,
    output logic             is_geo,
    output logic [DIR_W-1:0] rev
);
    logic [DIR_W-1:0] layer;
    logic [DIR_W-1:0] pos;
    logic [DIR_W-1:0] rlayer;
    logic [DIR_W-1:0] rpos;

    // Split the code into its layer and its position within the 3x3 ring.
    always_comb begin
        is_geo = (code < DIR_NGEO);
        layer  = code / 5'd9;
        pos    = code % 5'd9;
    end

    // Map the ring position and the layer to signed unit offsets.
    always_comb begin
        dx = 2'b00;
        dy = 2'b00;
        dz = 2'b00;
        if (is_geo) begin
            case (pos)
                5'd1, 5'd2, 5'd8: dx = 2'b01;
                5'd4, 5'd5, 5'd6: dx = 2'b11;
                default:          dx = 2'b00;
            endcase
            case (pos)
                5'd2, 5'd3, 5'd4: dy = 2'b01;
                5'd6, 5'd7, 5'd8: dy = 2'b11;
                default:          dy = 2'b00;
            endcase
            case (layer)
                5'd1:    dz = 2'b01;
                5'd2:    dz = 2'b11;
                default: dz = 2'b00;
            endcase
        end
    end

    // Opposite direction: swap the outer layers, turn the ring by half.
    always_comb begin
        rlayer = (layer == 5'd1) ? 5'd2 : (layer == 5'd2) ? 5'd1 : 5'd0;
        rpos   = (pos == 5'd0) ? 5'd0 : (((pos + 5'd3) % 5'd8) + 5'd1);
        rev    = is_geo ? (rlayer * 5'd9 + rpos) : code;
    end
endmodule

// File: rtl/geo_step.sv
// Applies a unit move to a pointer under the selected segment geometry.
// Assumes PTR_W = 2*GRID_W = 3*CUBE_W. Each coordinate wraps in its own field.
module geo_step
    import stepper_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [1:0]       dx,
    input  logic [1:0]       dy,
    input  logic [1:0]       dz,
    input  logic [1:0]       geom,
    output logic [PTR_W-1:0] next
);
    localparam int GRID_W = PTR_W / 2;
    localparam int CUBE_W = PTR_W / 3;

    logic [PTR_W-1:0]  lin_next;
    logic [GRID_W-1:0] gx, gy;
    logic [CUBE_W-1:0] cx, cy, cz;
    geom_e             g;

    // Per-geometry candidates; every field addition wraps in its own width.
    always_comb begin
        lin_next = ptr + {{(PTR_W-2){dx[1]}}, dx};
        gx = ptr[GRID_W-1:0]        + {{(GRID_W-2){dx[1]}}, dx};
        gy = ptr[2*GRID_W-1:GRID_W] + {{(GRID_W-2){dy[1]}}, dy};
        cx = ptr[CUBE_W-1:0]          + {{(CUBE_W-2){dx[1]}}, dx};
        cy = ptr[2*CUBE_W-1:CUBE_W]   + {{(CUBE_W-2){dy[1]}}, dy};
        cz = ptr[3*CUBE_W-1:2*CUBE_W] + {{(CUBE_W-2){dz[1]}}, dz};
    end

    // Choose the candidate for this segment's geometry.
    always_comb begin
        g = geom_e'(geom);
        case (g)
            GEO_GRID: next = {gy, gx};
            GEO_CUBE: next = {cz, cy, cx};
            default:  next = lin_next;
        endcase
    end
endmodule

// File: rtl/stride_step.sv
// Computes the next pointer for the stride codes and flags errors for the
// reserved codes and a zero modulus. Step is signed, modulus unsigned.
// Assumes the caller uses next only when the code is 27 or above.
module stride_step
    import stepper_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] step,
    input  logic [PTR_W-1:0] modv,
    input  logic [DIR_W-1:0] code,
    output logic [PTR_W-1:0] next,
    output logic             err
);
    localparam int SUM_W = PTR_W + 2;

    logic [PTR_W-1:0]        mod_safe;
    logic [PTR_W-1:0]        wrap_sum;
    logic [PTR_W-1:0]        res_wrap;
    logic [PTR_W-1:0]        off;
    logic [PTR_W-1:0]        base;
    logic [PTR_W-1:0]        res_block;
    logic signed [SUM_W-1:0] inner;
    logic signed [SUM_W-1:0] rem;
    logic signed [SUM_W-1:0] mod_s;
    logic                    uses_mod;

    // Modulo arithmetic for codes 28 and 29, with a divisor that is never zero.
    always_comb begin
        mod_safe  = (modv == '0) ? {{(PTR_W-1){1'b0}}, 1'b1} : modv;
        mod_s     = $signed({2'b00, mod_safe});
        wrap_sum  = ptr + step;
        res_wrap  = wrap_sum % mod_safe;
        off       = ptr % mod_safe;
        base      = ptr - off;
        inner     = $signed({2'b00, off}) + $signed({{2{step[PTR_W-1]}}, step});
        rem       = inner % mod_s;
        if (rem < 0) begin
            rem = rem + mod_s;
        end
        res_block = base + rem[PTR_W-1:0];
    end

    // Error detection and result selection; an error keeps the pointer.
    always_comb begin
        uses_mod = (code == DIR_WRAP) || (code == DIR_BLOCK);
        err      = (code >= DIR_RSV) || (uses_mod && (modv == '0));
        if (err) begin
            next = ptr;
        end else if (code == DIR_WRAP) begin
            next = res_wrap;
        end else if (code == DIR_BLOCK) begin
            next = res_block;
        end else begin
            next = ptr + step;
        end
    end
endmodule

// File: rtl/dir_ptr_stepper.sv
// Top of the direction-flag pointer stepper. It decodes the code, steps the
// pointer geometrically or by stride, and registers the result one cycle
// after in_valid. Assumes the inputs are stable at the sampling edge.
module dir_ptr_stepper
    import stepper_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [DIR_W-1:0] dir_in,
    input  logic [PTR_W-1:0] step_in,
    input  logic [PTR_W-1:0] mod_in,
    input  logic [1:0]       geom_in,
    output logic             out_valid,
    output logic [PTR_W-1:0] ptr_out,
    output logic [DIR_W-1:0] rev_out,
    output logic             err_out
);
    logic [1:0]       dx, dy, dz;
    logic             is_geo;
    logic [DIR_W-1:0] rev_c;
    logic [PTR_W-1:0] geo_next;
    logic [PTR_W-1:0] str_next;
    logic             str_err;
    logic [PTR_W-1:0] next_c;
    logic             err_c;

    dir_decode u_dec (
        .code   (dir_in),
        .dx     (dx),
        .dy     (dy),
        .dz     (dz),
        .is_geo (is_geo),
        .rev    (rev_c)
    );

    geo_step #(.PTR_W(PTR_W)) u_geo (
        .ptr  (ptr_in),
        .dx   (dx),
        .dy   (dy),
        .dz   (dz),
        .geom (geom_in),
        .next (geo_next)
    );

    stride_step #(.PTR_W(PTR_W)) u_str (
        .ptr  (ptr_in),
        .step (step_in),
        .modv (mod_in),
        .code (dir_in),
        .next (str_next),
        .err  (str_err)
    );

    // Pick the geometric or the stride result.
    always_comb begin
        next_c = is_geo ? geo_next : str_next;
        err_c  = is_geo ? 1'b0 : str_err;
    end

    // Output register: load on a request, otherwise hold the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ptr_out   <= '0;
            rev_out   <= '0;
            err_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ptr_out <= next_c;
                rev_out <= rev_c;
                err_out <= err_c;
            end
        end
    end

    // R2: a request gives a valid result on the next cycle.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: no request means no valid result, and the outputs hold.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(ptr_out) && $stable(err_out)));
    // R3: code 0 does not move the pointer.
    a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_in == 5'd0) |=> (ptr_out == $past(ptr_in)));
    // R8: the wrap code always lands below the modulus.
    a_r8_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_in == DIR_WRAP && mod_in != '0) |=> (ptr_out < $past(mod_in)));
    // R10: reserved codes raise the error.
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_in >= DIR_RSV) |=> err_out);
    // R10: a zero modulus on a modulus code raises the error.
    a_r10_zero_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (dir_in == DIR_WRAP || dir_in == DIR_BLOCK) && mod_in == '0) |=> err_out);
    // R10: geometric codes and the plain stride never report an error.
    a_r10_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_in <= DIR_STRIDE) |=> !err_out);
    // R10: an error keeps the pointer.
    a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!err_out || ptr_out == $past(ptr_in)));
    // R11: the non-geometric codes come back unchanged.
    a_r11_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_in >= DIR_NGEO) |=> (rev_out == $past(dir_in)));
endmodule

// File: tb/test_dir_ptr_stepper.sv
module test_dir_ptr_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;
    // {req(4), geom(2), dir(5), ptr(12), step(12), mod(12), exp_ptr(12), exp_err(1), exp_rev(5)}
    localparam logic [64:0] VEC [NV] = '{
        {4'd4,  2'd0, 5'd1,  12'h005, 12'h000, 12'h000, 12'h006, 1'b0, 5'd5},   // R4 forward
        {4'd4,  2'd0, 5'd10, 12'h005, 12'h000, 12'h000, 12'h006, 1'b0, 5'd23},  // R4 layer 1 forward
        {4'd4,  2'd0, 5'd19, 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0, 5'd14},  // R4 wrap up
        {4'd4,  2'd0, 5'd5,  12'h000, 12'h000, 12'h000, 12'hFFF, 1'b0, 5'd1},   // R4 wrap down
        {4'd3,  2'd0, 5'd3,  12'h123, 12'h000, 12'h000, 12'h123, 1'b0, 5'd7},   // R3 dx=0
        {4'd5,  2'd1, 5'd2,  12'h17F, 12'h000, 12'h000, 12'h180, 1'b0, 5'd6},   // R5 x wrap
        {4'd5,  2'd1, 5'd6,  12'h000, 12'h000, 12'h000, 12'hFFF, 1'b0, 5'd2},   // R5 both wrap
        {4'd5,  2'd1, 5'd13, 12'hFCA, 12'h000, 12'h000, 12'h009, 1'b0, 5'd26},  // R5 y wrap, dz ignored
        {4'd6,  2'd2, 5'd11, 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0, 5'd24},  // R6 all wrap up
        {4'd6,  2'd2, 5'd26, 12'h000, 12'h000, 12'h000, 12'hFF1, 1'b0, 5'd13},  // R6 mixed wrap
        {4'd3,  2'd2, 5'd0,  12'h456, 12'h000, 12'h000, 12'h456, 1'b0, 5'd0},   // R3 still
        {4'd7,  2'd1, 5'd27, 12'h100, 12'h010, 12'h000, 12'h110, 1'b0, 5'd27},  // R7 positive
        {4'd7,  2'd0, 5'd27, 12'h001, 12'hFFE, 12'h000, 12'hFFF, 1'b0, 5'd27},  // R7 negative
        {4'd8,  2'd0, 5'd28, 12'h007, 12'h005, 12'h00A, 12'h002, 1'b0, 5'd28},  // R8
        {4'd8,  2'd2, 5'd28, 12'h000, 12'hFFF, 12'h064, 12'h05F, 1'b0, 5'd28},  // R8 negative
        {4'd9,  2'd0, 5'd29, 12'h00E, 12'h003, 12'h008, 12'h009, 1'b0, 5'd29},  // R9
        {4'd9,  2'd0, 5'd29, 12'h008, 12'hFFF, 12'h008, 12'h00F, 1'b0, 5'd29},  // R9 negative
        {4'd9,  2'd1, 5'd29, 12'hFFF, 12'h007, 12'h00A, 12'hFFC, 1'b0, 5'd29},  // R9 top block
        {4'd9,  2'd0, 5'd29, 12'hFFF, 12'h003, 12'h064, 12'h002, 1'b0, 5'd29},  // R9 truncation
        {4'd10, 2'd0, 5'd30, 12'h234, 12'h001, 12'h005, 12'h234, 1'b1, 5'd30},  // R10 reserved
        {4'd10, 2'd2, 5'd31, 12'hABC, 12'h001, 12'h005, 12'hABC, 1'b1, 5'd31},  // R10 reserved
        {4'd10, 2'd0, 5'd28, 12'h321, 12'h001, 12'h000, 12'h321, 1'b1, 5'd28},  // R10 zero mod
        {4'd10, 2'd0, 5'd29, 12'h077, 12'h001, 12'h000, 12'h077, 1'b1, 5'd29},  // R10 zero mod
        {4'd4,  2'd3, 5'd1,  12'h010, 12'h000, 12'h000, 12'h011, 1'b0, 5'd5},   // R4 spare geometry
        {4'd7,  2'd0, 5'd27, 12'h050, 12'h001, 12'h000, 12'h051, 1'b0, 5'd27}   // R7 ignores mod
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] ptr_in = '0, step_in = '0, mod_in = '0;
    logic [4:0]  dir_in = '0;
    logic [1:0]  geom_in = '0;
    logic        out_valid, err_out;
    logic [11:0] ptr_out;
    logic [4:0]  rev_out;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_ptr_stepper i_dir_ptr_stepper (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ptr_in(ptr_in),
        .dir_in(dir_in), .step_in(step_in), .mod_in(mod_in), .geom_in(geom_in),
        .out_valid(out_valid), .ptr_out(ptr_out), .rev_out(rev_out), .err_out(err_out)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one request on a falling edge; the result is checked on the next falling edge.
    task automatic request(input logic [1:0] g, input logic [4:0] d, input logic [11:0] p,
                           input logic [11:0] s, input logic [11:0] m);
        @(negedge clk);
        geom_in = g; dir_in = d; ptr_in = p; step_in = s; mod_in = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "out_valid", 32'(out_valid), 0);
        check("R1", "ptr_out", 32'(ptr_out), 0);
        check("R1", "rev_out/err_out", {rev_out, err_out}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [64:0] v;
            string rq;
            v = VEC[i];
            rq = $sformatf("R%0d", v[64:61]);
            request(v[60:59], v[58:54], v[53:42], v[41:30], v[29:18]);
            check("R2", $sformatf("vector %0d out_valid", i), 32'(out_valid), 1);
            check(rq, $sformatf("vector %0d ptr_out", i), 32'(ptr_out), 32'(v[17:6]));
            check(rq, $sformatf("vector %0d err_out", i), 32'(err_out), 32'(v[5]));
            check("R11", $sformatf("vector %0d rev_out", i), 32'(rev_out), 32'(v[4:0]));
        end

        // R2: idle cycles with changing inputs leave the outputs alone.
        request(2'd0, 5'd1, 12'h200, 12'h0, 12'h0);
        @(negedge clk);
        dir_in = 5'd5; ptr_in = 12'h777; geom_in = 2'd2;
        repeat (2) @(negedge clk);
        check("R2", "idle out_valid", 32'(out_valid), 0);
        check("R2", "idle ptr_out held", 32'(ptr_out), 32'h201);
        check("R2", "idle rev_out held", 32'(rev_out), 5);

        // R2: back-to-back requests, one result per cycle.
        @(negedge clk);
        geom_in = 2'd0; dir_in = 5'd1; ptr_in = 12'h0A0; in_valid = 1'b1;
        @(negedge clk);
        check("R2", "b2b first", 32'(ptr_out), 32'h0A1);
        dir_in = 5'd14; ptr_in = 12'h0A0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "b2b second", 32'(ptr_out), 32'h09F);
        check("R11", "b2b second rev", 32'(rev_out), 5'd19);

        // R1: reset in mid-run clears the result.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "re-reset ptr_out", 32'(ptr_out), 0);
        check("R1", "re-reset rev/err/valid", {rev_out, err_out, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule